// File: doc/BRIEF.md
# Trace Cache with Block-Granular Fill Unit

This block keeps recently decoded instruction sequences as trace lines. A trace line follows the dynamic path through up to three conditional branches. The fill side receives the decoder's output one instruction per cycle. Each instruction carries its own PC, the PC that follows it on the decoded path, a basic-block end flag and a kind code. The fill unit groups these instructions into whole basic blocks and packs the blocks into a trace. It closes the trace by the termination rules below, and writes the finished trace into a 2-way, 32-set store.

On the fetch side, a lookup presents a fetch PC and a vector of predicted branch directions. One cycle later the block reports either a hit or a miss. A hit delivers the whole line at once: every instruction slot, the instruction count and the PC that follows the trace. A miss tells the fetch path to use the ordinary instruction path instead. Traces along wrongly predicted paths are written like any other trace. A flush input empties the store in one cycle.

Top module: `trace_fill_cache`

## Requirements
- R1: A lookup presented in cycle t reports its result in cycle t+1. In that cycle exactly one of lk_hit and lk_miss is high. Both are low in any cycle that follows a cycle without a lookup.
- R2: A hit needs a valid line whose stored start PC equals lk_pc. It also needs lk_pred bit i to equal the stored outcome of the i-th conditional branch in the trace (1 = taken), for every i below the line's branch count. Predicted bits at or above that count are ignored.
- R3: Two traces with the same start PC but different branch outcomes are kept side by side. Each is returned only for its own predicted pattern.
- R4: On a hit, lk_ops slot k (bits k*32 and up) holds the k-th instruction of the trace in fetch order. lk_cnt gives the instruction count and lk_nxt the successor PC of the last instruction. On a miss, lk_cnt and lk_nxt are zero.
- R5: A basic block ends on an instruction that has fill_bend set or fill_kind 1 (conditional branch) or 2 (indirect jump, call or return); kind 0 is a plain instruction. A block that reaches 16 instructions also ends there.
- R6: A block is never split. If it does not fit in the room left in the open trace, the open trace is written as it stands and the block begins a new trace.
- R7: A block ending in a kind-2 instruction closes the trace that contains it.
- R8: A trace closes as soon as it holds 3 conditional branches.
- R9: A trace closes as soon as it holds exactly 16 instructions.
- R10: The store has 32 sets of 2 ways, indexed by PC bits 6:2. A fill writes the least-recently-used way of its set, and a hit makes the other way least recently used.
- R11: A flush invalidates every line in one cycle. A lookup in the flush cycle misses, and a trace completed in the flush cycle is not kept.
- R12: When a block overflows the open trace and also closes its own new trace, both traces are written in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Invalidate all lines |
| fill_vld | input | 1 | Decoded instruction present |
| fill_pc | input | 32 | PC of the instruction |
| fill_op | input | 32 | Decoded instruction word |
| fill_nxt | input | 32 | PC following it on the decoded path |
| fill_bend | input | 1 | Last instruction of its basic block |
| fill_kind | input | 2 | 0 plain, 1 conditional branch, 2 indirect/call/return |
| fill_taken | input | 1 | Outcome of a conditional branch |
| lk_vld | input | 1 | Lookup request |
| lk_pc | input | 32 | Fetch PC |
| lk_pred | input | 3 | Predicted directions, bit i for branch i |
| lk_hit | output | 1 | Lookup hit |
| lk_miss | output | 1 | Lookup miss, fall back to normal fetch |
| lk_cnt | output | 5 | Instruction count of the hit line |
| lk_nxt | output | 32 | PC following the hit trace |
| lk_ops | output | 512 | All 16 instruction slots of the hit line |

## Verification
The bound checker watches every cycle for four things. Results appear only in the cycle after a request, a flushed lookup misses, a hit always carries a count of 1 to 16, and a miss always carries a zero count. It also watches every line the fill unit hands to the store: the count and branch count must stay within their caps, and a second write in one cycle must come with a first. Whether a trace was cut at the right block boundary, whether two paths from one start PC both survive, and which way replacement evicts can only be shown through the bench's scenarios. These are checked with sweeps over all eight predicted-direction patterns, with expected counts, successor PCs and slot contents worked out from the PCs the bench drove.

// File: rtl/tc_pkg.sv
package tc_pkg;
    parameter int unsigned PC_W   = 32;
    parameter int unsigned INST_W = 32;
    parameter int unsigned LINE_N = 16;
    parameter int unsigned BR_MAX = 3;
    parameter int unsigned SETS   = 32;

    localparam int unsigned CNT_W  = $clog2(LINE_N + 1);
    localparam int unsigned SLOT_W = $clog2(LINE_N);
    localparam int unsigned BRC_W  = $clog2(BR_MAX + 1);
    localparam int unsigned IDX_W  = $clog2(SETS);
    localparam int unsigned ALIGN  = 2;

    typedef enum logic [1:0] {
        K_PLAIN = 2'd0,
        K_COND  = 2'd1,
        K_END   = 2'd2
    } kind_e;

    typedef logic [LINE_N-1:0][INST_W-1:0] slots_t;

    typedef struct packed {
        logic              vld;
        logic [PC_W-1:0]   pc;
        logic [BRC_W-1:0]  brc;
        logic [BR_MAX-1:0] mask;
        logic [CNT_W-1:0]  cnt;
        logic [PC_W-1:0]   nxt;
        slots_t            ops;
    } line_t;

    typedef struct packed {
        line_t            tr;
        slots_t           bops;
        logic [CNT_W-1:0] bc;
        logic [PC_W-1:0]  bpc;
    } fill_t;
endpackage

// File: rtl/tc_fill.sv
module tc_fill
    import tc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_vld,
    input  logic [PC_W-1:0]   in_pc,
    input  logic [INST_W-1:0] in_op,
    input  logic [PC_W-1:0]   in_nxt,
    input  logic              in_bend,
    input  logic [1:0]        in_kind,
    input  logic              in_taken,
    output line_t             wr0,
    output line_t             wr1
);
    fill_t q, d;

    slots_t           blk;
    line_t            base;
    line_t            merged;
    logic [PC_W-1:0]  bstart;
    logic [CNT_W-1:0] nb;
    logic             is_cond;
    logic             is_term;
    logic             bend;
    logic             ovf;
    logic             close;

    always_comb begin
        d       = q;
        wr0     = '0;
        wr1     = '0;
        blk     = q.bops;
        base    = q.tr;
        merged  = q.tr;
        close   = 1'b0;
        bstart  = (q.bc == '0) ? in_pc : q.bpc;
        nb      = q.bc + 1'b1;
        is_cond = (in_kind == K_COND);
        is_term = (in_kind == K_END);
        bend    = in_bend | is_cond | is_term | (nb == CNT_W'(LINE_N));
        ovf     = (int'(q.tr.cnt) + int'(nb)) > int'(LINE_N);
        blk[q.bc[SLOT_W-1:0]] = in_op;

        if (in_vld) begin
            if (!bend) begin
                d.bops = blk;
                d.bc   = nb;
                d.bpc  = bstart;
            end else begin
                d.bc = '0;
                if (ovf) begin
                    wr0     = q.tr;
                    wr0.vld = 1'b1;
                    base    = '0;
                end
                if (base.cnt == '0) base.pc = bstart;
                merged = base;
                for (int k = 0; k < int'(LINE_N); k++) begin
                    if (k >= int'(base.cnt) && k < int'(base.cnt) + int'(nb))
                        merged.ops[k] = blk[SLOT_W'(k - int'(base.cnt))];
                end
                merged.cnt = base.cnt + nb;
                if (is_cond) begin
                    if (base.brc < BRC_W'(BR_MAX)) merged.mask[base.brc] = in_taken;
                    merged.brc = base.brc + 1'b1;
                end
                merged.nxt = in_nxt;
                close = is_term || (merged.brc == BRC_W'(BR_MAX)) ||
                        (merged.cnt == CNT_W'(LINE_N));
                if (close) begin
                    merged.vld = 1'b1;
                    if (ovf) wr1 = merged;
                    else     wr0 = merged;
                    d.tr = '0;
                end else begin
                    merged.vld = 1'b0;
                    d.tr       = merged;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/tc_store.sv
module tc_store
    import tc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  line_t             wr0,
    input  line_t             wr1,
    input  logic              lk_vld,
    input  logic [PC_W-1:0]   lk_pc,
    input  logic [BR_MAX-1:0] lk_pred,
    output logic              hit,
    output logic              miss,
    output logic [CNT_W-1:0]  cnt,
    output logic [PC_W-1:0]   nxt,
    output slots_t            ops
);
    typedef struct packed {
        logic [SETS-1:0]  lru;
        logic             hit;
        logic             miss;
        logic [CNT_W-1:0] cnt;
        logic [PC_W-1:0]  nxt;
        slots_t           ops;
    } sto_t;

    sto_t  q, d;
    line_t ln_q [SETS][2];
    line_t ln_d [SETS][2];

    logic [IDX_W-1:0] idx, i0, i1;
    logic [1:0]       match;
    logic             hway, w0, w1, lk_hit;
    logic [SETS-1:0]  lru;
    line_t            sel;

    function automatic logic pat_ok(line_t l, logic [BR_MAX-1:0] p);
        logic ok;
        ok = 1'b1;
        for (int b = 0; b < int'(BR_MAX); b++)
            if (b < int'(l.brc) && l.mask[b] != p[b]) ok = 1'b0;
        return ok;
    endfunction

    always_comb begin
        d    = q;
        ln_d = ln_q;
        idx  = lk_pc[IDX_W+ALIGN-1:ALIGN];
        for (int w = 0; w < 2; w++)
            match[w] = ln_q[idx][w].vld && (ln_q[idx][w].pc == lk_pc) &&
                       pat_ok(ln_q[idx][w], lk_pred);
        lk_hit = lk_vld && !flush && (|match);
        hway   = ~match[0];
        sel    = ln_q[idx][hway];
        d.hit  = lk_hit;
        d.miss = lk_vld && !lk_hit;
        d.cnt  = lk_hit ? sel.cnt : '0;
        d.nxt  = lk_hit ? sel.nxt : '0;
        d.ops  = lk_hit ? sel.ops : '0;

        lru = q.lru;
        if (lk_hit) lru[idx] = ~hway;
        i0 = wr0.pc[IDX_W+ALIGN-1:ALIGN];
        i1 = wr1.pc[IDX_W+ALIGN-1:ALIGN];
        w0 = lru[i0];
        if (wr0.vld) begin
            ln_d[i0][w0] = wr0;
            lru[i0]      = ~w0;
        end
        w1 = lru[i1];
        if (wr1.vld) begin
            ln_d[i1][w1] = wr1;
            lru[i1]      = ~w1;
        end
        d.lru = lru;

        if (flush) begin
            for (int s = 0; s < int'(SETS); s++)
                for (int w = 0; w < 2; w++)
                    ln_d[s][w].vld = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
            for (int s = 0; s < int'(SETS); s++)
                for (int w = 0; w < 2; w++)
                    ln_q[s][w] <= '0;
        end else begin
            q    <= d;
            ln_q <= ln_d;
        end
    end

    assign hit  = q.hit;
    assign miss = q.miss;
    assign cnt  = q.cnt;
    assign nxt  = q.nxt;
    assign ops  = q.ops;
endmodule

// File: rtl/trace_fill_cache.sv
module trace_fill_cache
    import tc_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     flush,
    input  logic                     fill_vld,
    input  logic [PC_W-1:0]          fill_pc,
    input  logic [INST_W-1:0]        fill_op,
    input  logic [PC_W-1:0]          fill_nxt,
    input  logic                     fill_bend,
    input  logic [1:0]               fill_kind,
    input  logic                     fill_taken,
    input  logic                     lk_vld,
    input  logic [PC_W-1:0]          lk_pc,
    input  logic [BR_MAX-1:0]        lk_pred,
    output logic                     lk_hit,
    output logic                     lk_miss,
    output logic [CNT_W-1:0]         lk_cnt,
    output logic [PC_W-1:0]          lk_nxt,
    output logic [LINE_N*INST_W-1:0] lk_ops
);
    line_t  wr0, wr1;
    slots_t ops;

    tc_fill u_fill (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_vld   (fill_vld),
        .in_pc    (fill_pc),
        .in_op    (fill_op),
        .in_nxt   (fill_nxt),
        .in_bend  (fill_bend),
        .in_kind  (fill_kind),
        .in_taken (fill_taken),
        .wr0      (wr0),
        .wr1      (wr1)
    );

    tc_store u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (flush),
        .wr0     (wr0),
        .wr1     (wr1),
        .lk_vld  (lk_vld),
        .lk_pc   (lk_pc),
        .lk_pred (lk_pred),
        .hit     (lk_hit),
        .miss    (lk_miss),
        .cnt     (lk_cnt),
        .nxt     (lk_nxt),
        .ops     (ops)
    );

    assign lk_ops = ops;
endmodule

// File: rtl/trace_fill_cache_chk.sv
module trace_fill_cache_chk
    import tc_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             flush,
    input logic             lk_vld,
    input logic             lk_hit,
    input logic             lk_miss,
    input logic [CNT_W-1:0] lk_cnt,
    input line_t            wr0,
    input line_t            wr1
);
    AST_LOOKUP_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_hit || lk_miss) |-> $past(lk_vld)); // R1

    AST_FLUSH_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && lk_vld) |=> (lk_miss && !lk_hit)); // R11

    AST_HIT_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (lk_cnt >= 1 && lk_cnt <= CNT_W'(LINE_N))); // R4

    AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        lk_miss |-> (lk_cnt == '0)); // R4

    AST_WRITE_CAPS0: assert property (@(posedge clk) disable iff (!rst_n)
        wr0.vld |-> (wr0.cnt >= 1 && wr0.cnt <= CNT_W'(LINE_N) &&
                     wr0.brc <= BRC_W'(BR_MAX))); // R8

    AST_WRITE_CAPS1: assert property (@(posedge clk) disable iff (!rst_n)
        wr1.vld |-> (wr1.cnt >= 1 && wr1.cnt <= CNT_W'(LINE_N) &&
                     wr1.brc <= BRC_W'(BR_MAX))); // R9

    AST_DOUBLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr1.vld |-> wr0.vld); // R12
endmodule

bind trace_fill_cache trace_fill_cache_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush   (flush),
    .lk_vld  (lk_vld),
    .lk_hit  (lk_hit),
    .lk_miss (lk_miss),
    .lk_cnt  (lk_cnt),
    .wr0     (wr0),
    .wr1     (wr1)
);

// File: tb/test_trace_fill_cache.sv
module test_trace_fill_cache;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         flush = 1'b0;
    logic         fill_vld = 1'b0;
    logic [31:0]  fill_pc = '0;
    logic [31:0]  fill_op = '0;
    logic [31:0]  fill_nxt = '0;
    logic         fill_bend = 1'b0;
    logic [1:0]   fill_kind = '0;
    logic         fill_taken = 1'b0;
    logic         lk_vld = 1'b0;
    logic [31:0]  lk_pc = '0;
    logic [2:0]   lk_pred = '0;
    logic         lk_hit, lk_miss;
    logic [4:0]   lk_cnt;
    logic [31:0]  lk_nxt;
    logic [511:0] lk_ops;

    int nchk = 0;
    int nerr = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    trace_fill_cache i_trace_fill_cache (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .fill_vld(fill_vld), .fill_pc(fill_pc), .fill_op(fill_op),
        .fill_nxt(fill_nxt), .fill_bend(fill_bend), .fill_kind(fill_kind),
        .fill_taken(fill_taken), .lk_vld(lk_vld), .lk_pc(lk_pc),
        .lk_pred(lk_pred), .lk_hit(lk_hit), .lk_miss(lk_miss),
        .lk_cnt(lk_cnt), .lk_nxt(lk_nxt), .lk_ops(lk_ops)
    );

    function automatic logic [31:0] opf(input logic [31:0] pc);
        return {pc[15:0], ~pc[15:0]};
    endfunction

    task automatic chk(input bit ok, input string rq,
                       input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    // one basic block of len instructions at consecutive PCs
    task automatic blk(input logic [31:0] pc, input int len, input logic [1:0] kind,
                       input bit tk, input bit fl_last);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            fill_vld   = 1'b1;
            fill_pc    = pc + 32'(4*i);
            fill_op    = opf(pc + 32'(4*i));
            fill_nxt   = pc + 32'(4*i + 4);
            fill_bend  = (i == len-1);
            fill_kind  = (i == len-1) ? kind : 2'd0;
            fill_taken = (i == len-1) && tk;
            flush      = (i == len-1) && fl_last;
        end
        @(negedge clk);
        fill_vld = 1'b0; fill_bend = 1'b0; fill_kind = '0; fill_taken = 1'b0; flush = 1'b0;
    endtask

    task automatic look(input logic [31:0] pc, input logic [2:0] pred, input bit fl,
                        input bit exp_hit, input int exp_cnt, input logic [31:0] exp_nxt,
                        input string rq);
        int bad;
        @(negedge clk);
        lk_vld = 1'b1; lk_pc = pc; lk_pred = pred; flush = fl;
        @(negedge clk);
        lk_vld = 1'b0; flush = 1'b0;
        chk(lk_hit == exp_hit && lk_miss == !exp_hit, {rq, " hit/miss"},
            {62'd0, lk_hit, lk_miss}, {62'd0, exp_hit, !exp_hit});
        if (exp_hit) begin
            chk(int'(lk_cnt) == exp_cnt, {rq, " R4 count"}, 64'(lk_cnt), 64'(exp_cnt));
            chk(lk_nxt == exp_nxt, {rq, " R4 next pc"}, 64'(lk_nxt), 64'(exp_nxt));
            bad = -1;
            for (int k = exp_cnt - 1; k >= 0; k--)
                if (lk_ops[k*32 +: 32] != opf(pc + 32'(4*k))) bad = k;
            chk(bad < 0, {rq, " R4 slot contents"}, 64'(bad), 64'hFFFFFFFF_FFFFFFFF);
        end else begin
            chk(lk_cnt == '0 && lk_nxt == '0, {rq, " R4 zero on miss"},
                {27'd0, lk_cnt, lk_nxt}, 64'd0);
        end
        @(negedge clk);
        chk(!lk_hit && !lk_miss, "R1 idle after lookup",
            {62'd0, lk_hit, lk_miss}, 64'd0);
    endtask

    task automatic do_flush();
        @(negedge clk); flush = 1'b1;
        @(negedge clk); flush = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!lk_hit && !lk_miss && lk_cnt == 0, "R1 reset state",
            {61'd0, lk_hit, lk_miss, |lk_cnt}, 64'd0);
        look(32'h1000, 3'd0, 0, 0, 0, 0, "R2 empty store");

        // R3 R8: two paths from one start PC, each closed at three branches
        blk(32'h3000, 2, 2'd1, 1, 0);
        blk(32'h3008, 2, 2'd1, 0, 0);
        blk(32'h3010, 2, 2'd1, 1, 0);
        blk(32'h3000, 3, 2'd1, 0, 0);
        blk(32'h300C, 3, 2'd1, 0, 0);
        blk(32'h3018, 3, 2'd1, 1, 0);
        for (int p = 0; p < 8; p++) begin
            if (p == 5)      look(32'h3000, 3'(p), 0, 1, 6, 32'h3018, "R3 R8 path 101");
            else if (p == 4) look(32'h3000, 3'(p), 0, 1, 9, 32'h3024, "R3 R8 path 100");
            else             look(32'h3000, 3'(p), 0, 0, 0, 0, "R3 other pattern");
        end

        // R2 R7: one branch then kind-2 end; upper predicted bits ignored
        do_flush();
        blk(32'h7000, 3, 2'd1, 0, 0);
        blk(32'h700C, 2, 2'd2, 0, 0);
        for (int p = 0; p < 8; p++)
            look(32'h7000, 3'(p), 0, p[0] == 1'b0, 5, 32'h7014, "R2 R7 partial mask");
        look(32'h7080, 3'd0, 0, 0, 0, 0, "R2 same set other pc");

        // R11: flush-cycle lookup, flushed contents, dropped fill
        look(32'h7000, 3'd0, 1, 0, 0, 0, "R11 lookup during flush");
        look(32'h7000, 3'd0, 0, 0, 0, 0, "R11 flushed line");
        blk(32'h7100, 2, 2'd2, 0, 1);
        look(32'h7100, 3'd0, 0, 0, 0, 0, "R11 fill in flush cycle dropped");
        blk(32'h7100, 2, 2'd2, 0, 0);
        look(32'h7100, 3'd0, 0, 1, 2, 32'h7108, "R11 fill after flush kept");

        // R5 R9: a 20-instruction run splits at 16
        do_flush();
        blk(32'h4000, 20, 2'd2, 0, 0);
        look(32'h4000, 3'd7, 0, 1, 16, 32'h4040, "R5 R9 forced block end at 16");
        look(32'h4040, 3'd2, 0, 1, 4, 32'h4050, "R5 R7 remainder trace");

        // R6: block that does not fit starts a new trace
        do_flush();
        blk(32'h6000, 10, 2'd0, 0, 0);
        blk(32'h6028, 7, 2'd0, 0, 0);
        blk(32'h6044, 5, 2'd2, 0, 0);
        look(32'h6000, 3'd0, 0, 1, 10, 32'h6028, "R6 closed before overflow");
        look(32'h6028, 3'd3, 0, 1, 12, 32'h6058, "R6 block begins new trace");

        // R12: overflow plus closing block writes two traces
        do_flush();
        blk(32'h5000, 10, 2'd0, 0, 0);
        blk(32'h5028, 8, 2'd2, 0, 0);
        look(32'h5000, 3'd0, 0, 1, 10, 32'h5028, "R12 first of pair");
        look(32'h5028, 3'd0, 0, 1, 8, 32'h5048, "R12 second of pair");

        // R10: LRU replacement within set 0
        do_flush();
        blk(32'h2000, 2, 2'd2, 0, 0);
        blk(32'h2080, 2, 2'd2, 0, 0);
        look(32'h2000, 3'd0, 0, 1, 2, 32'h2008, "R10 touch A");
        blk(32'h2100, 2, 2'd2, 0, 0);
        look(32'h2000, 3'd0, 0, 1, 2, 32'h2008, "R10 recent A kept");
        look(32'h2080, 3'd0, 0, 0, 0, 0, "R10 LRU B evicted");
        look(32'h2100, 3'd0, 0, 1, 2, 32'h2108, "R10 C filled");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule